// File: doc/BRIEF.md
# Multi-Rate Punctured Convolutional Encoder

This block takes a serial stream of data bits and encodes each one with a rate-1/2 convolutional code. The code has constraint length 7, six delay stages and generators 177 and 133 in octal. A mode value captured at the start of each block selects one of three output rates: 1/2, 2/3 or 3/4. At rate 1/2 both coded bits of every input bit are sent. At the two higher rates, some coded bits are dropped at fixed positions within a repeating group of input bits.

Everything runs in one clock domain, and the output carries at most one coded bit per clock. The output side is a bit with a valid strobe. A small output buffer absorbs the difference between input and output rates, and the input side applies backpressure through a ready flag. A single-cycle block-start pulse clears the encoder history and the puncture phase, and it latches the mode value. Tail termination, interleaving and modulation are outside this block.

Top module: `puncture_conv_enc`

## Requirements
- R1: At rate 1/2, every accepted bit u emits two bits, X1 then X2. With the window w = {u, s1..s6}, where s1 is the newest stored bit, X1 is the parity of w AND 7'o177 and X2 is the parity of w AND 7'o133.
- R2: At rate 3/4, the puncture phase cycles 0, 1, 2 over accepted bits. Phase 0 emits X1 then X2, phase 1 emits only X1 and phase 2 emits only X2, so a 144-bit block produces 192 output bits.
- R3: At rate 2/3, the puncture phase cycles 0, 1. Phase 0 emits X1 then X2 and phase 1 emits only X1, so every 2 input bits produce 3 output bits.
- R4: The mode value 4'b1111 selects rate 3/4, 4'b0011 selects rate 2/3, and every other value of the 4-bit mode input selects rate 1/2.
- R5: The mode input is sampled only in a cycle where the start pulse is high. Changes at any other time have no effect on the output stream.
- R6: A start pulse clears all six delay stages and sets the puncture phase to 0. If a bit is accepted in the same cycle as the start pulse, that bit is encoded as the first bit of the new block.
- R7: After reset, the output valid flag is low and the input ready flag is high.
- R8: A bit is taken only in a cycle where both the input valid and the ready flag are high. The input bit has no effect in every other cycle. Ready is low while the buffer holds more than DEPTH-2 bits.
- R9: Buffered bits leave in order, one per clock, with no gaps while the buffer is non-empty. No bit is lost or duplicated.
- R10: A coded bit kept from an input accepted at a clock edge is visible on the output after that same edge, if the buffer was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Block-start pulse; clears history and phase, samples mode |
| mode | input | 4 | Rate select, sampled with blk_start |
| in_valid | input | 1 | Input bit qualifier |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Block can accept a bit this cycle |
| out_valid | output | 1 | out_bit carries a coded bit |
| out_bit | output | 1 | Serial coded bit |

## Verification
A wrong delay-stage value shows up in the very next coded bit that uses that tap, and it keeps corrupting output bits for up to six further inputs. A wrong puncture phase changes which coded bits appear right away, and it also shifts the output bit count for the block. A buffer count that drifts shows up as a duplicated, missing or misordered bit within a few cycles, or as a stalled ready flag. The bench sweeps all 16 mode values and compares every output bit against an arithmetic model, so each of these faults appears as a bit or count mismatch.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [1:0] {
        RATE_12 = 2'd0,
        RATE_23 = 2'd1,
        RATE_34 = 2'd2
    } rate_e;

    localparam logic [3:0] MODE_SEL_R23 = 4'b0011;
    localparam logic [3:0] MODE_SEL_R34 = 4'b1111;

    function automatic rate_e decode_mode(input logic [3:0] m);
        case (m)
            MODE_SEL_R34: return RATE_34;
            MODE_SEL_R23: return RATE_23;
            default:      return RATE_12;
        endcase
    endfunction

    // number of input bits in one puncture period
    function automatic logic [1:0] period_of(input rate_e r);
        case (r)
            RATE_34: return 2'd3;
            RATE_23: return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

    // bit0 keeps X1, bit1 keeps X2
    function automatic logic [1:0] keep_mask(input rate_e r, input logic [1:0] ph);
        case (r)
            RATE_34: begin
                case (ph)
                    2'd0:    return 2'b11;
                    2'd1:    return 2'b01;
                    default: return 2'b10;
                endcase
            end
            RATE_23: return (ph == 2'd0) ? 2'b11 : 2'b01;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/pce_conv_core.sv
module pce_conv_core #(
    parameter int          K  = 7,
    parameter logic [K-1:0] G1 = 7'o177,
    parameter logic [K-1:0] G2 = 7'o133
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic bit_in,
    output logic x1,
    output logic x2
);
    localparam int SW = K - 1;

    typedef struct packed {
        logic [SW-1:0] sreg;
    } core_st_t;

    core_st_t cur_q, nxt_d;
    logic [SW-1:0] base;
    logic [K-1:0]  window;

    always_comb begin
        nxt_d  = cur_q;
        base   = clear ? '0 : cur_q.sreg;
        window = {bit_in, base};
        x1     = ^(window & G1);
        x2     = ^(window & G2);
        if (advance) begin
            nxt_d.sreg = window[K-1:1];
        end else if (clear) begin
            nxt_d.sreg = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !advance) |=> (cur_q.sreg == '0)); // R6

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (cur_q.sreg[SW-1] == $past(bit_in))); // R1

endmodule

// File: rtl/pce_puncture_ctl.sv
module pce_puncture_ctl
    import pce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] mode_in,
    input  logic       accept,
    output logic [1:0] keep
);
    typedef struct packed {
        rate_e      rate;
        logic [1:0] phase;
    } punc_st_t;

    punc_st_t cur_q, nxt_d;
    rate_e      eff_rate;
    logic [1:0] eff_phase;
    logic [1:0] inc_phase;

    always_comb begin
        eff_rate  = start ? decode_mode(mode_in) : cur_q.rate;
        eff_phase = start ? 2'd0 : cur_q.phase;
        inc_phase = eff_phase + 2'd1;
        keep      = keep_mask(eff_rate, eff_phase);
        nxt_d.rate  = eff_rate;
        nxt_d.phase = eff_phase;
        if (accept) begin
            nxt_d.phase = (inc_phase == period_of(eff_rate)) ? 2'd0 : inc_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{rate: RATE_12, phase: 2'd0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.phase < period_of(cur_q.rate)); // R2

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cur_q.rate)); // R5

    AST_KEEP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (keep != 2'b00)); // R3

endmodule

// File: rtl/pce_out_serializer.sv
module pce_out_serializer #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] push_keep,
    input  logic [1:0] push_data,
    output logic       room2,
    output logic       out_valid,
    output logic       out_bit
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic [CW-1:0]    cnt;
    } ser_st_t;

    ser_st_t cur_q, nxt_d;
    logic [CW-1:0] widx;
    logic [CW-1:0] widx2;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt != '0) begin
            nxt_d.bits = cur_q.bits >> 1;
            nxt_d.cnt  = cur_q.cnt - 1'b1;
        end
        widx  = nxt_d.cnt;
        widx2 = widx + CW'(push_keep[0]);
        for (int i = 0; i < DEPTH; i++) begin
            if (push_keep[0] && (CW'(i) == widx)) begin
                nxt_d.bits[i] = push_data[0];
            end
            if (push_keep[1] && (CW'(i) == widx2)) begin
                nxt_d.bits[i] = push_data[1];
            end
        end
        nxt_d.cnt = widx2 + CW'(push_keep[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign room2     = (cur_q.cnt <= CW'(DEPTH - 2));
    assign out_valid = (cur_q.cnt != '0);
    assign out_bit   = cur_q.bits[0];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CW'(DEPTH)); // R8

    AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (push_keep != 2'b00) |-> (cur_q.cnt <= CW'(DEPTH - 2))); // R8

    AST_VALID_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (push_keep != 2'b00) |=> out_valid); // R10

    AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && push_keep == 2'b00) |=> (cur_q.cnt == $past(cur_q.cnt) - 1'b1)); // R9

endmodule

// File: rtl/puncture_conv_enc.sv
module puncture_conv_enc #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blk_start,
    input  logic [3:0] mode,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       in_ready,
    output logic       out_valid,
    output logic       out_bit
);
    logic       accept;
    logic       x1;
    logic       x2;
    logic [1:0] keep;
    logic [1:0] push_keep;
    logic       room2;

    assign in_ready  = room2;
    assign accept    = in_valid && room2;
    assign push_keep = keep & {2{accept}};

    pce_conv_core #(
        .K  (7),
        .G1 (7'o177),
        .G2 (7'o133)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (blk_start),
        .advance (accept),
        .bit_in  (in_bit),
        .x1      (x1),
        .x2      (x2)
    );

    pce_puncture_ctl u_punc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (blk_start),
        .mode_in (mode),
        .accept  (accept),
        .keep    (keep)
    );

    pce_out_serializer #(
        .DEPTH (DEPTH)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_keep (push_keep),
        .push_data ({x2, x1}),
        .room2     (room2),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    AST_ACCEPT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (push_keep != 2'b00) |-> (in_valid && in_ready)); // R8

endmodule

// File: tb/tb_puncture_conv_enc.sv
module tb_puncture_conv_enc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_start = 1'b0;
    logic [3:0] mode = 4'h0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic       out_bit;

    always #10 clk = ~clk;

    puncture_conv_enc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .mode      (mode),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    int    checks = 0;
    int    errors = 0;
    int    out_cnt = 0;
    int    notready_cnt = 0;
    string cur_req = "R1";
    bit    exp_q[$];

    // reference model state
    bit [5:0] ms = '0;
    int       mrate = 0;   // 0:1/2 1:2/3 2:3/4
    int       mph = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rate_of(input logic [3:0] m);
        if (m == 4'b1111) return 2;
        if (m == 4'b0011) return 1;
        return 0;
    endfunction

    function automatic void model_accept(input bit u);
        bit [6:0] w;
        bit a, b, k1, k2;
        w = {u, ms};
        a = ^(w & 7'o177);
        b = ^(w & 7'o133);
        k1 = 1; k2 = 1;
        if (mrate == 2) begin k1 = (mph != 2); k2 = (mph != 1); end
        if (mrate == 1) begin k2 = (mph == 0); end
        if (k1) exp_q.push_back(a);
        if (k2) exp_q.push_back(b);
        ms  = w[6:1];
        mph = (mph + 1 == mrate + 1) ? 0 : mph + 1;
    endfunction

    // output monitor: every emitted bit is compared in order
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, cur_req, "unexpected output bit", 1, 0);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(out_bit == e, cur_req, "output bit", out_bit, e);
            end
            out_cnt++;
        end
    end

    task automatic send(input int n, input logic [3:0] m, input bit do_start,
                        input int gap_pct);
        int  sent;
        bit  first;
        sent  = 0;
        first = do_start;
        while (sent < n) begin
            @(negedge clk);
            mode      = m;
            blk_start = 1'b0;
            in_valid  = 1'b0;
            in_bit    = 1'($urandom);
            if (first) begin
                blk_start = 1'b1;
                first     = 0;
                ms        = '0;
                mph       = 0;
                mrate     = rate_of(m);
            end
            if (int'($urandom_range(99)) >= gap_pct) begin
                in_valid = 1'b1;
                if (in_ready) begin
                    model_accept(in_bit);
                    sent++;
                end else begin
                    notready_cnt++;
                end
            end
        end
        @(negedge clk);
        blk_start = 1'b0;
        in_valid  = 1'b0;
    endtask

    task automatic drain(input string req, input int exp_cnt);
        for (int i = 0; i < 40; i++) begin
            if (exp_q.size() == 0 && !out_valid) break;
            @(negedge clk);
        end
        @(negedge clk);
        check(exp_q.size() == 0, req, "bits still expected", exp_q.size(), 0);
        check(out_cnt == exp_cnt, req, "output bit count", out_cnt, exp_cnt);
        exp_q.delete();
        out_cnt = 0;
    endtask

    task automatic finish_up;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid idle", out_valid, 0);

        // R10: first bit visible right after the accepting edge
        cur_req = "R10";
        mode = 4'h0; blk_start = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
        ms = '0; mph = 0; mrate = 0;
        model_accept(1'b1);
        @(negedge clk);
        check(out_valid == 1'b1, "R10", "out_valid one edge after accept", out_valid, 1);
        blk_start = 1'b0; in_valid = 1'b0;
        drain("R10", 2);

        // R1: rate 1/2 continuous stream, with backpressure observed
        cur_req = "R1";
        notready_cnt = 0;
        send(60, 4'b0000, 1, 0);
        drain("R1", 120);
        check(notready_cnt > 0, "R8", "ready dropped at rate 1/2", notready_cnt, 1);

        // R2: 144-bit block at rate 3/4 gives 192 bits
        cur_req = "R2";
        send(144, 4'b1111, 1, 0);
        drain("R2", 192);

        // R3: rate 2/3
        cur_req = "R3";
        send(96, 4'b0011, 1, 0);
        drain("R3", 144);

        // R4: sweep of every mode value
        cur_req = "R4";
        for (int m = 0; m < 16; m++) begin
            int r;
            r = rate_of(4'(m));
            send(24, 4'(m), 1, 0);
            drain("R4", (r == 2) ? 32 : (r == 1) ? 36 : 48);
        end

        // R5: mode changes without start have no effect
        cur_req = "R5";
        send(6, 4'b1111, 1, 0);
        send(6, 4'b0000, 0, 0);
        send(6, 4'b0011, 0, 0);
        drain("R5", 24);

        // R6: start mid-block clears history and phase
        cur_req = "R6";
        send(5, 4'b1111, 1, 0);
        send(7, 4'b1111, 1, 0);
        drain("R6", 17);
        send(3, 4'b0011, 1, 0);
        send(4, 4'b0000, 1, 0);
        drain("R6", 13);

        // R8: gaps with garbage on in_bit while in_valid is low
        cur_req = "R8";
        send(60, 4'b0011, 1, 40);
        drain("R8", 90);
        send(40, 4'b1111, 1, 60);
        drain("R8", 54);

        // R9: long mixed run, in-order with no loss
        cur_req = "R9";
        send(120, 4'b0101, 1, 20);
        drain("R9", 240);

        finish_up();
    end

endmodule